// File: doc/BRIEF.md
# SMBus Register Slave

This block is a bus target for a two-wire serial bus (SMBus/I2C). It oversamples the serial clock and data lines on the system clock through a short synchronizer and finds start and stop conditions from the synchronized levels. It then shifts in a 7-bit target address and a direction bit, and answers only its own address. The address is a fixed upper part plus two low bits taken from strap inputs, so up to four copies can share one bus. The data line is driven only low, through an enable output. The surrounding pad forms the open-drain connection.

A write transfer always starts with a pointer byte. Every later byte in that transfer is stored at the register the pointer selects, and the pointer then advances. A read transfer cannot carry a pointer. It returns bytes from wherever the last write left the pointer and advances after each byte. The read continues while the controller acknowledges each byte and ends when it does not.

The map holds a small bank of writable byte registers from address 0x00 upward. Four fixed identification bytes sit at 0xF4 to 0xF7. Every other address reads as zero. Writes to the identification bytes and to unmapped addresses are dropped.

Top module: `smb_reg_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start. It abandons any transfer in progress and restarts address reception at bit 0, including a start that arrives in the middle of a byte.
- R2: After a start, 8 bits are taken MSB first: a 7-bit address and then the direction bit (0 = write, 1 = read). The target address is {ADDR_HI, addr_sel_i}. On a match the block holds SDA low over the ninth clock to acknowledge.
- R3: On an address mismatch the block never drives SDA. It ignores every byte until the next start.
- R4: In a write transfer, the first byte after the address loads the register pointer and is acknowledged.
- R5: Each further byte of a write transfer is acknowledged and stored at the pointer, and the pointer then increments by one.
- R6: In a read transfer, bytes come from the current pointer MSB first. SDA changes only while SCL is low. The pointer increments after each byte, and the next byte is loaded only after the controller acknowledges.
- R7: When the controller does not acknowledge a read byte, the block releases SDA. It keeps SDA released on any further clocks until a stop or a start.
- R8: Address 0xF4 reads 0x41, 0xF5 reads 0x02, and 0xF6 and 0xF7 read 0x00. Writes to these four addresses have no effect.
- R9: Registers 0x00 to NUM_REGS-1 are writable and reset to 0x00. All other addresses read 0x00 and ignore writes.
- R10: A rising SDA while SCL is high is a stop and returns the block to idle. SDA is released in reset and in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel_i | input | 2 | Low two bits of the target address |
| sda_oe_o | output | 1 | Drive SDA low when 1 |

## Verification
A set of single-register write transactions, each followed by a separate pointer-only read, covers several kinds of address. These are writable registers at both ends of the bank, the identification bytes, the first address past the bank and a far unmapped one. Together they separate a true store from a dropped write and from the fixed identification values. Burst writes and acknowledged burst reads show that the pointer advances per byte and that the next byte is loaded only after an acknowledge. A foreign address, a changed strap value, a start injected mid-byte, and extra clocks after a not-acknowledge each check whether the block stays silent or restarts cleanly.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } smb_state_e;

  localparam logic [7:0] ID_BASE = 8'hF4;

  function automatic logic [7:0] id_value(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h41;
      2'd1:    return 8'h02;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edges only count while SCL stayed high across both samples
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/smb_reg_file.sv
module smb_reg_file import smb_pkg::*; #(
  parameter int NUM_REGS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [7:0] rd_addr_i,
  output logic [7:0] rd_data_o
);
  localparam int         IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [7:0] LIMIT = 8'(NUM_REGS);

  logic [7:0] regs [NUM_REGS];
  logic       wr_hit;

  assign wr_hit = wr_en_i && (wr_addr_i < LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_REGS; k++) regs[k] <= 8'h00;
    end else if (wr_hit) begin
      regs[wr_addr_i[IDX_W-1:0]] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    if (rd_addr_i < LIMIT)
      rd_data_o = regs[rd_addr_i[IDX_W-1:0]];
    else if (rd_addr_i[7:2] == ID_BASE[7:2])
      rd_data_o = id_value(rd_addr_i[1:0]);
  end
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave import smb_pkg::*; #(
  parameter logic [4:0] ADDR_HI     = 5'b10110,
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_sel_i,
  output logic       sda_oe_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  smb_state_e state_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] shreg_q, txsh_q, ptr_q, rd_data;
  logic       rw_q, ack_ok_q, oe_q;
  logic [6:0] own_addr;
  logic       byte_done, wr_en;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smb_reg_file #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(ptr_q), .wr_data_i(shreg_q),
    .rd_addr_i(ptr_q), .rd_data_o(rd_data)
  );

  assign own_addr  = {ADDR_HI, addr_sel_i};
  assign byte_done = (bit_cnt_q == 4'd8);
  assign wr_en     = (state_q == ST_WR) && scl_fall && byte_done;
  assign sda_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      txsh_q    <= '0;
      ptr_q     <= '0;
      rw_q      <= 1'b0;
      ack_ok_q  <= 1'b0;
      oe_q      <= 1'b0;
    end else if (start_det) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (stop_det) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_CMD, ST_WR: begin
          if (scl_rise) begin
            shreg_q   <= {shreg_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall && byte_done) begin
            bit_cnt_q <= '0;
            if (state_q == ST_ADDR) begin
              if (shreg_q[7:1] == own_addr) begin
                oe_q    <= 1'b1;
                rw_q    <= shreg_q[0];
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_CMD) begin
              ptr_q   <= shreg_q;
              oe_q    <= 1'b1;
              state_q <= ST_CMD_ACK;
            end else begin
              ptr_q   <= ptr_q + 8'd1;
              oe_q    <= 1'b1;
              state_q <= ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          if (rw_q) begin
            txsh_q  <= {rd_data[6:0], 1'b0};
            oe_q    <= ~rd_data[7];
            state_q <= ST_RD;
          end else begin
            oe_q    <= 1'b0;
            state_q <= ST_CMD;
          end
        end
        ST_CMD_ACK, ST_WR_ACK: if (scl_fall) begin
          oe_q    <= 1'b0;
          state_q <= ST_WR;
        end
        ST_RD: begin
          if (scl_rise) begin
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (byte_done) begin
              oe_q      <= 1'b0;
              bit_cnt_q <= '0;
              ptr_q     <= ptr_q + 8'd1;
              state_q   <= ST_RD_ACK;
            end else begin
              oe_q   <= ~txsh_q[7];
              txsh_q <= {txsh_q[6:0], 1'b0};
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            ack_ok_q <= ~sda_s;
          end else if (scl_fall) begin
            if (ack_ok_q) begin
              txsh_q  <= {rd_data[6:0], 1'b0};
              oe_q    <= ~rd_data[7];
              state_q <= ST_RD;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk import smb_pkg::*; #(
  parameter logic [4:0] ADDR_HI = 5'b10110
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_hi,
  input logic       start_det,
  input smb_state_e state_q,
  input logic [3:0] bit_cnt_q,
  input logic [7:0] shreg_q,
  input logic [1:0] addr_sel_i,
  input logic       sda_oe_o
);
  assert_start_restart_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (state_q == ST_ADDR && bit_cnt_q == 4'd0));

  assert_ack_own_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_o) && $past(state_q) == ST_ADDR) |->
      ($past(shreg_q[7:1]) == {ADDR_HI, $past(addr_sel_i)}));

  assert_sda_moves_scl_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(scl_hi) |-> $stable(sda_oe_o));

  assert_nack_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_RD_ACK && state_q == ST_IDLE) |-> !sda_oe_o);

  assert_idle_released_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_o);
endmodule

bind smb_reg_slave smb_reg_slave_chk #(.ADDR_HI(ADDR_HI)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_hi(scl_s), .start_det(start_det),
  .state_q(state_q), .bit_cnt_q(bit_cnt_q), .shreg_q(shreg_q),
  .addr_sel_i(addr_sel_i), .sda_oe_o(sda_oe_o)
);

// File: tb/tb_smb_reg_slave.sv
module tb_smb_reg_slave;
  localparam int Q = 8;
  localparam logic [4:0] HI = 5'b10110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] sel = 2'b01;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  smb_reg_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel_i(sel), .sda_oe_o(sda_oe)
  );

  // {pointer, written byte, expected readback}
  localparam logic [23:0] VEC [9] = '{
    {8'h00, 8'h5A, 8'h5A}, {8'h0F, 8'hC3, 8'hC3}, {8'h07, 8'hFF, 8'hFF},
    {8'hF4, 8'h99, 8'h41}, {8'hF5, 8'h99, 8'h02}, {8'hF6, 8'h99, 8'h00},
    {8'hF7, 8'h77, 8'h00}, {8'h20, 8'hAB, 8'h00}, {8'h10, 8'h12, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(Q); scl_m = 1'b1; hw(Q); sda_m = 1'b0; hw(Q); scl_m = 1'b0; hw(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw(Q); scl_m = 1'b1; hw(Q); sda_m = 1'b1; hw(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; hw(Q); scl_m = 1'b1; hw(Q); scl_m = 1'b0; hw(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; hw(Q); scl_m = 1'b1; hw(Q/2);
    ack = ~sda_line;
    hw(Q/2); scl_m = 1'b0; hw(Q);
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] d);
    sda_m = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      hw(Q); scl_m = 1'b1; hw(Q/2);
      d = {d[6:0], sda_line};
      hw(Q/2); scl_m = 1'b0;
    end
    hw(Q); sda_m = ~give_ack; hw(Q); scl_m = 1'b1; hw(Q); scl_m = 1'b0;
    hw(2); sda_m = 1'b1; hw(Q);
  endtask

  function automatic logic [7:0] addr_byte(input logic [1:0] s, input logic rd);
    return {HI, s, rd};
  endfunction

  task automatic set_ptr(input logic [7:0] p);
    logic a;
    bus_start(); wr_byte(addr_byte(sel, 1'b0), a); wr_byte(p, a); bus_stop();
  endtask

  task automatic read_one(output logic [7:0] d);
    logic a;
    bus_start(); wr_byte(addr_byte(sel, 1'b1), a); rd_byte(1'b0, d); bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    hw(5);
    chk("R10 reset release", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    hw(5);

    // R9 reset value of a writable register
    set_ptr(8'h05); read_one(d);
    chk("R9 reset value", d, 8'h00);

    for (int i = 0; i < 9; i++) begin
      bus_start();
      wr_byte(addr_byte(sel, 1'b0), a);
      chk("R2 address ack", {7'd0, a}, 8'h01);
      wr_byte(VEC[i][23:16], a);
      wr_byte(VEC[i][15:8], a);
      bus_stop();
      set_ptr(VEC[i][23:16]);
      read_one(d);
      chk("R5/R8/R9 readback", d, VEC[i][7:0]);
    end

    // R3 foreign address is ignored
    bus_start();
    wr_byte(8'h24, a); chk("R3 no ack foreign", {7'd0, a}, 8'h00);
    wr_byte(8'h00, a); chk("R3 no ack data", {7'd0, a}, 8'h00);
    wr_byte(8'hEE, a);
    bus_stop();
    set_ptr(8'h00); read_one(d);
    chk("R3 reg unchanged", d, 8'h5A);

    // R2 strap bits select the address
    sel = 2'b10; hw(2);
    bus_start(); wr_byte(addr_byte(2'b01, 1'b0), a); bus_stop();
    chk("R2 old strap ignored", {7'd0, a}, 8'h00);
    bus_start(); wr_byte(addr_byte(2'b10, 1'b0), a); bus_stop();
    chk("R2 new strap acked", {7'd0, a}, 8'h01);

    // R4 R5 burst write, R6 burst read
    bus_start(); wr_byte(addr_byte(sel, 1'b0), a);
    wr_byte(8'h03, a); chk("R4 pointer ack", {7'd0, a}, 8'h01);
    wr_byte(8'h11, a); wr_byte(8'h22, a); wr_byte(8'h33, a);
    chk("R5 burst ack", {7'd0, a}, 8'h01);
    bus_stop();
    set_ptr(8'h03);
    bus_start(); wr_byte(addr_byte(sel, 1'b1), a);
    rd_byte(1'b1, d); chk("R6 burst byte0", d, 8'h11);
    rd_byte(1'b1, d); chk("R6 burst byte1", d, 8'h22);
    rd_byte(1'b0, d); chk("R6 burst byte2", d, 8'h33);
    // R7 released after not-acknowledge, even with extra clocks
    begin
      logic seen = 1'b0;
      for (int k = 0; k < 9; k++) begin
        hw(Q); scl_m = 1'b1; hw(Q/2); seen |= sda_oe; hw(Q/2); scl_m = 1'b0;
      end
      hw(Q);
      chk("R7 no drive after nack", {7'd0, seen}, 8'h00);
    end
    bus_stop();

    // R8 identification block burst
    set_ptr(8'hF4);
    bus_start(); wr_byte(addr_byte(sel, 1'b1), a);
    rd_byte(1'b1, d); chk("R8 id F4", d, 8'h41);
    rd_byte(1'b1, d); chk("R8 id F5", d, 8'h02);
    rd_byte(1'b1, d); chk("R8 id F6", d, 8'h00);
    rd_byte(1'b0, d); chk("R8 id F7", d, 8'h00);
    bus_stop();

    // R1 start in the middle of a byte restarts address reception
    bus_start(); wr_byte(addr_byte(sel, 1'b0), a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    wr_byte(addr_byte(sel, 1'b0), a); chk("R1 ack after restart", {7'd0, a}, 8'h01);
    wr_byte(8'h02, a); wr_byte(8'h66, a);
    bus_stop();
    set_ptr(8'h02); read_one(d);
    chk("R1 write after restart", d, 8'h66);
    hw(Q);
    chk("R10 idle release", {7'd0, sda_oe}, 8'h00);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule